// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the word address used by a serial EEPROM slave to reach its byte array. The address is 17 bits wide and covers 512 pages of 256 bytes. The protocol engine around it fills the address in three parts as bytes arrive. The page bit comes from the device-select byte. Bits 15:8 come from the first address byte, and bits 7:0 come from the second. Once a data byte has moved over the bus, the engine pulses a single step strobe.

A load of the page bit also latches the transfer direction. While the direction is write, a step moves only the in-page offset, so a long burst wraps back to byte 0 of the same page and overwrites older data there. While the direction is read, a step advances the whole address, and the address wraps from the top of the array to zero. Between transfers the counter holds its value. A current-address read then starts from the byte that follows the last one accessed.

All controls are single-cycle strobes sampled on the rising clock edge. The address output is registered and changes one cycle after the strobe that caused the change. The block carries no data stream, so its pins are plain control and status signals with no handshake.

Top module: `eeaddr_counter`

## Requirements
- R1: While `rst_n` is low, the address and the latched direction clear to zero (write). The address reads 0 after the first clock edge in reset.
- R2: A `ld_page_i` strobe copies bit 1 of `ld_byte_i` into address bit 16 and leaves bits 15:0 unchanged.
- R3: A `ld_hi_i` strobe copies `ld_byte_i` into address bits 15:8 and leaves the other bits unchanged.
- R4: A `ld_lo_i` strobe copies `ld_byte_i` into address bits 7:0 and leaves the other bits unchanged.
- R5: In write direction, a `step_i` strobe adds one to bits 7:0 modulo 256 and keeps bits 16:8. Offset 255 steps to offset 0 of the same page.
- R6: In read direction, a `step_i` strobe adds one to the full address modulo 2^17. Address 0x1FFFF steps to 0x00000, and a step at offset 255 carries into the next page.
- R7: If any load strobe is high in the same cycle as `step_i`, the step has no effect. Only the loaded fields change.
- R8: The direction is latched from `rd_mode_i` (1 = read, 0 = write) only on a `ld_page_i` strobe. At any other time, changes on `rd_mode_i` do not alter how later steps behave.
- R9: In a cycle with no strobe, the address holds its value, so a later current-address access sees the last address accessed plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_page_i | input | 1 | Load page bit from select byte and latch direction |
| ld_hi_i | input | 1 | Load address bits 15:8 |
| ld_lo_i | input | 1 | Load address bits 7:0 |
| ld_byte_i | input | 8 | Byte supplying the loaded field |
| rd_mode_i | input | 1 | Direction sampled on page load: 1 read, 0 write |
| step_i | input | 1 | Advance address after a data byte |
| addr_o | output | 17 | Current word address |

## Verification
The properties assume that the strobes are clean synchronous levels, sampled only at the rising edge. They also assume that `ld_byte_i` is stable whenever a load strobe is high. No protocol ordering is assumed: any mix of strobes, including a load and a step in the same cycle, is legal. The stimulus changes every input only on the falling edge, which keeps setup clean. It deliberately combines overlapping strobes, direction toggles without a page load, and steps that start at offsets 0xFE/0xFF and at address 0x1FFFE, so that every wrap boundary is crossed.

// File: rtl/eeaddr_pkg.sv
package eeaddr_pkg;
  typedef enum logic {
    STEP_PAGE   = 1'b0,
    STEP_LINEAR = 1'b1
  } step_mode_e;
endpackage

// File: rtl/eeaddr_load.sv
module eeaddr_load #(
  parameter int ADDR_W       = 17,
  parameter int BYTE_W       = 8,
  parameter int PAGE_BIT_POS = 1
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              ld_page,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [BYTE_W-1:0] ld_byte,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              any_load
);
  localparam int HI_LSB = BYTE_W;
  localparam int PG_LSB = 2 * BYTE_W;
  localparam int PAGE_W = ADDR_W - PG_LSB;

  always_comb begin
    nxt_addr = cur_addr;
    if (ld_page) nxt_addr[PG_LSB +: PAGE_W] = ld_byte[PAGE_BIT_POS +: PAGE_W];
    if (ld_hi)   nxt_addr[HI_LSB +: BYTE_W] = ld_byte;
    if (ld_lo)   nxt_addr[0 +: BYTE_W]      = ld_byte;
    any_load = ld_page | ld_hi | ld_lo;
  end
endmodule

// File: rtl/eeaddr_step.sv
module eeaddr_step
  import eeaddr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  step_mode_e        mode,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [OFS_W-1:0]  ofs_inc;
  logic [ADDR_W-1:0] page_nxt;
  logic [ADDR_W-1:0] lin_nxt;

  always_comb begin
    ofs_inc  = cur_addr[OFS_W-1:0] + OFS_W'(1);
    page_nxt = {cur_addr[ADDR_W-1:OFS_W], ofs_inc};
    lin_nxt  = cur_addr + ADDR_W'(1);
    nxt_addr = (mode == STEP_LINEAR) ? lin_nxt : page_nxt;
  end
endmodule

// File: rtl/eeaddr_counter.sv
module eeaddr_counter
  import eeaddr_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int BYTE_W       = 8,
  parameter int PAGE_BIT_POS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_page_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [BYTE_W-1:0] ld_byte_i,
  input  logic              rd_mode_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] load_nxt;
  logic [ADDR_W-1:0] step_nxt;
  logic              any_load;
  step_mode_e        mode_q;

  eeaddr_load #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .PAGE_BIT_POS(PAGE_BIT_POS)
  ) u_load (
    .cur_addr(addr_q), .ld_page(ld_page_i), .ld_hi(ld_hi_i), .ld_lo(ld_lo_i),
    .ld_byte(ld_byte_i), .nxt_addr(load_nxt), .any_load(any_load)
  );

  eeaddr_step #(
    .ADDR_W(ADDR_W), .OFS_W(BYTE_W)
  ) u_step (
    .cur_addr(addr_q), .mode(mode_q), .nxt_addr(step_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= STEP_PAGE;
    end else begin
      if (any_load)    addr_q <= load_nxt;
      else if (step_i) addr_q <= step_nxt;
      if (ld_page_i)   mode_q <= rd_mode_i ? STEP_LINEAR : STEP_PAGE;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/eeaddr_counter_chk.sv
module eeaddr_counter_chk #(
  parameter int ADDR_W = 17,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_page_i,
  input logic              ld_hi_i,
  input logic              ld_lo_i,
  input logic [BYTE_W-1:0] ld_byte_i,
  input logic              rd_mode_i,
  input logic              step_i,
  input logic              mode_q,
  input logic [ADDR_W-1:0] addr_o
);
  localparam int HI_LSB = BYTE_W;
  logic no_ld;
  assign no_ld = !(ld_page_i || ld_hi_i || ld_lo_i);

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> addr_o == '0);

  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi_i |=> addr_o[HI_LSB +: BYTE_W] == $past(ld_byte_i));

  p_lo_load_r4_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_i |=> addr_o[BYTE_W-1:0] == $past(ld_byte_i));

  p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && no_ld && !mode_q) |=>
      (addr_o[ADDR_W-1:BYTE_W] == $past(addr_o[ADDR_W-1:BYTE_W])) &&
      (addr_o[BYTE_W-1:0] == BYTE_W'($past(addr_o[BYTE_W-1:0]) + BYTE_W'(1))));

  p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && no_ld && mode_q) |=> addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1)));

  p_mode_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_page_i |=> mode_q == $past(rd_mode_i));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_page_i |=> $stable(mode_q));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ld && !step_i) |=> $stable(addr_o));
endmodule

bind eeaddr_counter eeaddr_counter_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_page_i(ld_page_i), .ld_hi_i(ld_hi_i),
  .ld_lo_i(ld_lo_i), .ld_byte_i(ld_byte_i), .rd_mode_i(rd_mode_i),
  .step_i(step_i), .mode_q(mode_q), .addr_o(addr_o)
);

// File: tb/tb_eeaddr_counter.sv
`timescale 1ns/1ps
module tb_eeaddr_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_page_i = 1'b0, ld_hi_i = 1'b0, ld_lo_i = 1'b0;
  logic [7:0]  ld_byte_i = 8'h00;
  logic        rd_mode_i = 1'b0;
  logic        step_i = 1'b0;
  logic [16:0] addr_o;

  int    errors = 0;
  int    checks = 0;
  int    m_addr = 0;
  bit    m_rd = 0;
  bit    done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  eeaddr_counter dut (
    .clk(clk), .rst_n(rst_n), .ld_page_i(ld_page_i), .ld_hi_i(ld_hi_i),
    .ld_lo_i(ld_lo_i), .ld_byte_i(ld_byte_i), .rd_mode_i(rd_mode_i),
    .step_i(step_i), .addr_o(addr_o)
  );

  task automatic model_edge();
    if (!rst_n) begin
      m_addr = 0; m_rd = 0;
    end else if (ld_page_i || ld_hi_i || ld_lo_i) begin
      if (ld_page_i) begin
        m_addr = (m_addr % 65536) + (ld_byte_i[1] ? 65536 : 0);
        m_rd   = rd_mode_i;
      end
      if (ld_hi_i) m_addr = (m_addr / 65536) * 65536 + ld_byte_i * 256 + (m_addr % 256);
      if (ld_lo_i) m_addr = (m_addr / 256) * 256 + ld_byte_i;
    end else if (step_i) begin
      if (m_rd) m_addr = (m_addr + 1) % 131072;
      else      m_addr = (m_addr / 256) * 256 + ((m_addr % 256) + 1) % 256;
    end
  endtask

  task automatic tick(input bit pg, input bit hi, input bit lo, input logic [7:0] b,
                      input bit rd, input bit st);
    ld_page_i = pg; ld_hi_i = hi; ld_lo_i = lo; ld_byte_i = b;
    rd_mode_i = rd; step_i = st;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (addr_o !== 17'(m_addr)) begin
      errors++;
      $display("FAIL %s: addr_o actual=%05h expected=%05h", tag, addr_o, m_addr);
    end
  endtask

  initial begin
    @(negedge clk);
    tag = "R1";
    tick(0, 0, 0, 8'h00, 0, 0);
    tick(1, 1, 1, 8'hFF, 1, 1);
    rst_n = 1'b1;
    tag = "R2"; tick(1, 0, 0, 8'hA2, 0, 0);
    tag = "R3"; tick(0, 1, 0, 8'h34, 0, 0);
    tag = "R4"; tick(0, 0, 1, 8'hFE, 0, 0);
    tag = "R5";
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 8'h00, 0, 1);
    tag = "R9";
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 8'h5A, 0, 0);
    tag = "R8";
    tick(0, 0, 1, 8'hFF, 1, 0);
    tick(0, 0, 0, 8'h00, 1, 1);
    tick(0, 0, 0, 8'h00, 1, 1);
    tag = "R6";
    tick(1, 0, 0, 8'hA3, 1, 0);
    tick(0, 1, 0, 8'hFF, 0, 0);
    tick(0, 0, 1, 8'hFE, 0, 0);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 8'h00, 0, 1);
    tick(1, 0, 0, 8'hA1, 1, 0);
    tick(0, 1, 1, 8'h00, 1, 0);
    tick(0, 0, 1, 8'hFF, 1, 0);
    tick(0, 0, 0, 8'h00, 0, 1);
    tick(0, 0, 0, 8'h00, 0, 1);
    tag = "R2"; tick(1, 0, 0, 8'hA0, 0, 0);
    tag = "R7";
    tick(0, 0, 1, 8'h80, 0, 1);
    tick(0, 1, 0, 8'h12, 0, 1);
    tick(1, 0, 0, 8'hA2, 1, 1);
    tag = "R9";
    tick(0, 0, 0, 8'h00, 0, 0);
    tag = "R5";
    for (int i = 0; i < 40; i++)
      tick(i % 7 == 0, i % 5 == 0, i % 11 == 0, 8'(i * 37 + 3), i % 3 == 0, i % 2 == 0);
    tag = "R1";
    rst_n = 1'b0;
    tick(0, 0, 0, 8'h00, 0, 1);
    rst_n = 1'b1;
    tick(0, 0, 0, 8'h00, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule